// File: doc/BRIEF.md
# Instruction Register Pipeline Controller

This block holds the instruction words of a three-stage 16-bit pipeline as they move from fetch to decode and from decode to execute. A decode-stage register and an execute-stage register both load only when the pipeline advances. A one-entry spare buffer holds an instruction whose fetch finished early in a pipeline cycle, so the word survives the later memory cycles in that pipeline cycle that go to DMA or to a load or store. On the next advance the decode register takes the word from this buffer and not from the memory port.

The block also handles control flow. A pending interrupt is taken by placing a synthetic link-and-jump word in the decode register in place of the fetched word. The interrupt waits while the decode instruction must not be split from its successor, while a flow instruction is in decode, or while a redirect is in execute. A jump or taken branch in execute marks both younger instructions as annulled. An annulled instruction still runs but cannot write the register file. The block also generates the register-file write strobe and the select for the A-operand bypass.

Top module: `irpipe_ctrl`

## Requirements
- R1: While rst_n is low and in the first cycle after it rises, dc_insn and ex_insn are 0x0000, dc_annul and ex_annul are 1, ret_hold is 0, and the spare buffer is empty.
- R2: When advance is low, dc_insn and ex_insn hold. On an advance, ex_insn takes the old dc_insn, and dc_insn takes its selected source one cycle later. Fields are opcode [15:12], destination [11:8], A source [7:4] and B source [3:0].
- R3: A cycle with fetch_ok high and advance low stores fetch_word in the spare buffer. The next advance loads dc_insn from the buffer and ignores fetch_word. Any advance empties the buffer.
- R4: An irq pulse makes an interrupt pending. On the first advance where it is not deferred, dc_insn becomes 0xAE08 (opcode 0xA link-and-jump, destination r14, base r0, word offset 8, meaning byte address 0x0010). That word replaces the spare and the port, and the pending flag clears.
- R5: The interrupt is deferred while the decode opcode is one of the interlocked ones: 0x0 add, 0x1 sub, 0x2 add-immediate, 0x5 shift, 0xD immediate prefix.
- R6: The interrupt is also deferred while the decode opcode is a flow opcode (0xA link-jump, 0xB branch, 0xC call). It is also deferred while execute holds a redirect.
- R7: A redirect is a non-annulled execute instruction that is 0xA or 0xC, or that is 0xB with br_taken high. A redirect on an advance sets both dc_annul and ex_annul. Any other advance moves dc_annul into ex_annul and clears dc_annul.
- R8: ret_hold is high from the advance that inserts the interrupt word until the next advance.
- R9: rf_wr_en is high only while advance is high and the execute instruction produces a result. Opcodes 0x8, 0x9 (stores), 0xB, 0xD, 0xE and 0xF produce none. The instruction must also be non-annulled, and its destination must not be r0.
- R10: The destination of opcode 0xC is r15 whatever bits [11:8] hold. Every other opcode uses bits [11:8].
- R11: a_bypass is high when the execute instruction would write (R9 without the advance term) and its destination equals dc_insn[7:4]. The B operand is never bypassed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| advance | input | 1 | Pipeline advance enable |
| fetch_ok | input | 1 | Instruction fetch completes this cycle |
| fetch_word | input | 16 | Word on the memory read port |
| irq | input | 1 | Interrupt request |
| br_taken | input | 1 | Branch condition of the execute instruction is true |
| dc_insn | output | 16 | Decode-stage instruction |
| ex_insn | output | 16 | Execute-stage instruction |
| dc_annul | output | 1 | Decode instruction is annulled |
| ex_annul | output | 1 | Execute instruction is annulled |
| rf_wr_en | output | 1 | Register-file write enable |
| a_bypass | output | 1 | Route the result bus to the A operand |
| ret_hold | output | 1 | Hold the return-address register |

## Verification
The hardest cases to reach are interrupt deferral and spare-buffer reuse. Both depend on which opcodes sit in decode and execute at the moment of an advance. The directed part of the stimulus builds these cases step by step. An irq arrives while an add waits in decode. A second irq arrives while a branch sits in decode and then turns into a taken redirect. A fetch followed by a stalled cycle fills the spare while the port carries garbage. After that, a long random stream of advances, fetches, requests and branch outcomes runs against an arithmetic model of the pipeline.

// File: rtl/irp_pkg.sv
package irp_pkg;
  localparam int INSN_W = 16;
  localparam int OP_W   = 4;
  localparam int REG_W  = 4;
  localparam int OP_LSB = INSN_W - OP_W;
  localparam int RD_LSB = OP_LSB - REG_W;
  localparam int RA_LSB = RD_LSB - REG_W;
  localparam int RB_LSB = RA_LSB - REG_W;

  typedef logic [INSN_W-1:0] insn_t;
  typedef logic [OP_W-1:0]   op_t;
  typedef logic [REG_W-1:0]  reg_t;

  localparam op_t OP_ADD  = 4'h0;
  localparam op_t OP_SUB  = 4'h1;
  localparam op_t OP_ADDI = 4'h2;
  localparam op_t OP_LOGR = 4'h3;
  localparam op_t OP_LOGI = 4'h4;
  localparam op_t OP_SHF  = 4'h5;
  localparam op_t OP_LDW  = 4'h6;
  localparam op_t OP_LDB  = 4'h7;
  localparam op_t OP_STW  = 4'h8;
  localparam op_t OP_STB  = 4'h9;
  localparam op_t OP_JAL  = 4'hA;
  localparam op_t OP_BR   = 4'hB;
  localparam op_t OP_CALL = 4'hC;
  localparam op_t OP_IMM  = 4'hD;
  localparam op_t OP_RSVE = 4'hE;
  localparam op_t OP_RSVF = 4'hF;

  localparam reg_t CALL_LINK = '1;

  function automatic op_t f_op(insn_t i);
    return i[OP_LSB +: OP_W];
  endfunction

  function automatic reg_t f_rd(insn_t i);
    return i[RD_LSB +: REG_W];
  endfunction

  function automatic reg_t f_ra(insn_t i);
    return i[RA_LSB +: REG_W];
  endfunction

  // instruction that must stay glued to its successor
  function automatic logic f_interlock(op_t op);
    return op inside {OP_ADD, OP_SUB, OP_ADDI, OP_SHF, OP_IMM};
  endfunction

  function automatic logic f_flow(op_t op);
    return op inside {OP_JAL, OP_BR, OP_CALL};
  endfunction

  function automatic logic f_uncond(op_t op);
    return op inside {OP_JAL, OP_CALL};
  endfunction

  function automatic logic f_no_result(op_t op);
    return op inside {OP_STW, OP_STB, OP_BR, OP_IMM, OP_RSVE, OP_RSVF};
  endfunction

  function automatic reg_t f_dest(op_t op, reg_t rd);
    return (op == OP_CALL) ? CALL_LINK : rd;
  endfunction

  function automatic insn_t f_jal_word(reg_t rd, reg_t ra, reg_t off);
    return {OP_JAL, rd, ra, off};
  endfunction
endpackage

// File: rtl/irp_ir_stage.sv
module irp_ir_stage
  import irp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  advance,
  input  logic  fetch_ok,
  input  insn_t fetch_word,
  input  logic  inject,
  input  insn_t int_word,
  output insn_t dc_insn,
  output insn_t ex_insn
);
  insn_t spare_q;
  logic  spare_vld_q;
  insn_t src_w;

  always_comb begin
    if (inject)           src_w = int_word;
    else if (spare_vld_q) src_w = spare_q;
    else                  src_w = fetch_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dc_insn     <= '0;
      ex_insn     <= '0;
      spare_q     <= '0;
      spare_vld_q <= 1'b0;
    end else if (advance) begin
      dc_insn     <= src_w;
      ex_insn     <= dc_insn;
      spare_vld_q <= 1'b0;
    end else if (fetch_ok) begin
      spare_q     <= fetch_word;
      spare_vld_q <= 1'b1;
    end
  end
endmodule

// File: rtl/irp_annul.sv
module irp_annul
  import irp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic advance,
  input  op_t  ex_op,
  input  logic br_taken,
  output logic dc_annul,
  output logic ex_annul,
  output logic redirect
);
  assign redirect = !ex_annul &&
                    (f_uncond(ex_op) || (ex_op == OP_BR && br_taken));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dc_annul <= 1'b1;
      ex_annul <= 1'b1;
    end else if (advance) begin
      dc_annul <= redirect;
      ex_annul <= redirect || dc_annul;
    end
  end
endmodule

// File: rtl/irp_irq.sv
module irp_irq
  import irp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic advance,
  input  logic irq,
  input  op_t  dc_op,
  input  logic redirect,
  output logic inject,
  output logic defer,
  output logic ret_hold
);
  logic pend_q;

  assign defer  = f_interlock(dc_op) || f_flow(dc_op) || redirect;
  assign inject = advance && pend_q && !defer;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      ret_hold <= 1'b0;
    end else begin
      pend_q <= inject ? 1'b0 : (pend_q || irq);
      if (advance) ret_hold <= inject;
    end
  end
endmodule

// File: rtl/irp_wb.sv
module irp_wb
  import irp_pkg::*;
(
  input  logic advance,
  input  op_t  ex_op,
  input  reg_t ex_rd,
  input  logic ex_annul,
  input  reg_t dc_ra,
  output logic rf_wr_en,
  output logic a_bypass
);
  reg_t dest_w;
  logic live_w;

  assign dest_w   = f_dest(ex_op, ex_rd);
  assign live_w   = !ex_annul && !f_no_result(ex_op) && (dest_w != '0);
  assign rf_wr_en = advance && live_w;
  assign a_bypass = live_w && (dc_ra == dest_w);
endmodule

// File: rtl/irpipe_ctrl.sv
module irpipe_ctrl
  import irp_pkg::*;
#(
  parameter int LINK_REG = 14,
  parameter int VEC_BYTE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic              fetch_ok,
  input  logic [INSN_W-1:0] fetch_word,
  input  logic              irq,
  input  logic              br_taken,
  output logic [INSN_W-1:0] dc_insn,
  output logic [INSN_W-1:0] ex_insn,
  output logic              dc_annul,
  output logic              ex_annul,
  output logic              rf_wr_en,
  output logic              a_bypass,
  output logic              ret_hold
);
  localparam insn_t INT_WORD =
    f_jal_word(reg_t'(LINK_REG), '0, reg_t'(VEC_BYTE / 2));

  logic redirect_w;
  logic inject_w;
  logic defer_w;
  op_t  dc_op_w;
  op_t  ex_op_w;
  reg_t ex_rd_w;
  reg_t dc_ra_w;

  assign dc_op_w = f_op(dc_insn);
  assign ex_op_w = f_op(ex_insn);
  assign ex_rd_w = f_rd(ex_insn);
  assign dc_ra_w = f_ra(dc_insn);

  irp_ir_stage u_ir (
    .clk(clk), .rst_n(rst_n), .advance(advance), .fetch_ok(fetch_ok),
    .fetch_word(fetch_word), .inject(inject_w), .int_word(INT_WORD),
    .dc_insn(dc_insn), .ex_insn(ex_insn)
  );

  irp_annul u_annul (
    .clk(clk), .rst_n(rst_n), .advance(advance), .ex_op(ex_op_w),
    .br_taken(br_taken), .dc_annul(dc_annul), .ex_annul(ex_annul),
    .redirect(redirect_w)
  );

  irp_irq u_irq (
    .clk(clk), .rst_n(rst_n), .advance(advance), .irq(irq),
    .dc_op(dc_op_w), .redirect(redirect_w), .inject(inject_w),
    .defer(defer_w), .ret_hold(ret_hold)
  );

  irp_wb u_wb (
    .advance(advance), .ex_op(ex_op_w), .ex_rd(ex_rd_w),
    .ex_annul(ex_annul), .dc_ra(dc_ra_w), .rf_wr_en(rf_wr_en),
    .a_bypass(a_bypass)
  );
endmodule

// File: rtl/irpipe_chk.sv
module irpipe_chk #(
  parameter logic [15:0] INT_WORD = 16'hAE08
) (
  input logic        clk,
  input logic        rst_n,
  input logic        advance,
  input logic [15:0] dc_insn,
  input logic [15:0] ex_insn,
  input logic        dc_annul,
  input logic        ex_annul,
  input logic        rf_wr_en,
  input logic        a_bypass,
  input logic        ret_hold,
  input logic        redirect,
  input logic        inject,
  input logic        defer
);
  a_r2_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> ($stable(dc_insn) && $stable(ex_insn)));

  a_r2_shift: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (ex_insn == $past(dc_insn)));

  a_r4_int_word: assert property (@(posedge clk) disable iff (!rst_n)
    inject |=> (dc_insn == INT_WORD));

  a_r6_no_inject_deferred: assert property (@(posedge clk) disable iff (!rst_n)
    inject |-> (!redirect && !defer));

  a_r7_annul_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && redirect) |=> (dc_annul && ex_annul));

  a_r8_ret_hold: assert property (@(posedge clk) disable iff (!rst_n)
    inject |=> ret_hold);

  a_r9_write_needs_adv: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en |-> advance);

  a_r9_annul_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    ex_annul |-> !rf_wr_en);

  a_r11_bypass_live: assert property (@(posedge clk) disable iff (!rst_n)
    a_bypass |-> !ex_annul);
endmodule

bind irpipe_ctrl irpipe_chk #(.INT_WORD(INT_WORD)) u_chk (
  .clk(clk), .rst_n(rst_n), .advance(advance), .dc_insn(dc_insn),
  .ex_insn(ex_insn), .dc_annul(dc_annul), .ex_annul(ex_annul),
  .rf_wr_en(rf_wr_en), .a_bypass(a_bypass), .ret_hold(ret_hold),
  .redirect(redirect_w), .inject(inject_w), .defer(defer_w)
);

// File: tb/irpipe_ctrl_tb.sv
module irpipe_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        advance = 1'b0;
  logic        fetch_ok = 1'b0;
  logic [15:0] fetch_word = '0;
  logic        irq = 1'b0;
  logic        br_taken = 1'b0;
  logic [15:0] dc_insn, ex_insn;
  logic        dc_annul, ex_annul, rf_wr_en, a_bypass, ret_hold;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // reference model state
  logic [15:0] m_dc, m_ex, m_sp;
  logic        m_dca, m_exa, m_spv, m_pend, m_hold;
  logic        pre_wr, pre_byp;

  always #(CLK_PERIOD/2) clk = ~clk;

  irpipe_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .advance(advance), .fetch_ok(fetch_ok),
    .fetch_word(fetch_word), .irq(irq), .br_taken(br_taken),
    .dc_insn(dc_insn), .ex_insn(ex_insn), .dc_annul(dc_annul),
    .ex_annul(ex_annul), .rf_wr_en(rf_wr_en), .a_bypass(a_bypass),
    .ret_hold(ret_hold)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit gives_result(logic [3:0] op);
    case (op)
      4'h8, 4'h9, 4'hB, 4'hD, 4'hE, 4'hF: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic bit holds_irq(logic [3:0] op);
    case (op)
      4'h0, 4'h1, 4'h2, 4'h5, 4'hD, 4'hA, 4'hB, 4'hC: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic step(input logic a, input logic f, input logic [15:0] w,
                      input logic q, input logic b);
    logic [3:0] xo;
    logic [3:0] dst;
    bit redir, wr, inj;
    @(negedge clk);
    advance = a; fetch_ok = f; fetch_word = w; irq = q; br_taken = b;
    #1;
    xo    = m_ex[15:12];
    dst   = (xo == 4'hC) ? 4'hF : m_ex[11:8];
    redir = !m_exa && (xo == 4'hA || xo == 4'hC || (xo == 4'hB && b));
    wr    = !m_exa && gives_result(xo) && dst != 4'h0;
    inj   = a && m_pend && !holds_irq(m_dc[15:12]) && !redir;
    pre_wr  = rf_wr_en;
    pre_byp = a_bypass;
    chk(rf_wr_en == (a && wr), "R9 rf_wr_en", {15'd0, rf_wr_en}, {15'd0, a && wr});
    chk(a_bypass == (wr && m_dc[7:4] == dst), "R11 a_bypass",
        {15'd0, a_bypass}, {15'd0, wr && m_dc[7:4] == dst});
    @(posedge clk);
    if (a) begin
      m_ex   = m_dc;
      m_dc   = inj ? 16'hAE08 : (m_spv ? m_sp : w);
      m_exa  = redir || m_dca;
      m_dca  = redir;
      m_spv  = 1'b0;
      m_hold = inj;
    end else if (f) begin
      m_sp  = w;
      m_spv = 1'b1;
    end
    m_pend = inj ? 1'b0 : (m_pend || q);
    #1;
    chk(dc_insn == m_dc, "R2 dc_insn", dc_insn, m_dc);
    chk(ex_insn == m_ex, "R2 ex_insn", ex_insn, m_ex);
    chk({dc_annul, ex_annul} == {m_dca, m_exa}, "R7 annul flags",
        {14'd0, dc_annul, ex_annul}, {14'd0, m_dca, m_exa});
    chk(ret_hold == m_hold, "R8 ret_hold", {15'd0, ret_hold}, {15'd0, m_hold});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    m_dc = '0; m_ex = '0; m_sp = '0; m_dca = 1; m_exa = 1;
    m_spv = 0; m_pend = 0; m_hold = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(dc_insn == 16'h0000 && ex_insn == 16'h0000, "R1 insn regs", dc_insn, 16'h0000);
    chk(dc_annul && ex_annul, "R1 annul flags", {14'd0, dc_annul, ex_annul}, 16'h0003);
    chk(!ret_hold && !rf_wr_en, "R1 ret_hold/write", {14'd0, ret_hold, rf_wr_en}, 16'h0000);

    step(1, 1, 16'h0123, 0, 0);
    step(1, 1, 16'h0512, 0, 0);
    step(1, 1, 16'h0154, 0, 0);
    step(0, 1, 16'h6AAA, 0, 0);           // spare capture, stall
    chk(pre_byp == 1'b1, "R11 bypass A from r5", {15'd0, pre_byp}, 16'h0001);
    chk(dc_insn == 16'h0154, "R2 stall hold", dc_insn, 16'h0154);
    step(1, 0, 16'hFFFF, 0, 0);
    chk(dc_insn == 16'h6AAA, "R3 spare used, port ignored", dc_insn, 16'h6AAA);
    chk(pre_wr == 1'b1, "R9 add r5 writes", {15'd0, pre_wr}, 16'h0001);
    step(1, 1, 16'h8123, 0, 0);
    chk(dc_insn == 16'h8123, "R3 spare emptied", dc_insn, 16'h8123);
    step(1, 1, 16'h0012, 0, 0);
    step(1, 1, 16'h2000, 0, 0);
    chk(pre_wr == 1'b0, "R9 store no write", {15'd0, pre_wr}, 16'h0000);
    step(1, 1, 16'h0000, 0, 0);
    chk(pre_wr == 1'b0, "R9 r0 dest no write", {15'd0, pre_wr}, 16'h0000);

    step(0, 0, 16'h0000, 1, 0);           // interrupt pending, add in decode
    step(1, 1, 16'h6111, 0, 0);
    chk(dc_insn == 16'h6111, "R5 deferred behind add", dc_insn, 16'h6111);
    step(1, 1, 16'h7222, 0, 0);
    chk(dc_insn == 16'hAE08, "R4 interrupt word", dc_insn, 16'hAE08);
    chk(ret_hold == 1'b1, "R8 hold after insert", {15'd0, ret_hold}, 16'h0001);
    step(0, 0, 16'h0000, 0, 0);
    chk(ret_hold == 1'b1, "R8 hold across stall", {15'd0, ret_hold}, 16'h0001);
    step(1, 1, 16'h1333, 0, 0);
    chk(ret_hold == 1'b0, "R8 hold released", {15'd0, ret_hold}, 16'h0000);
    step(1, 1, 16'h4444, 0, 0);
    chk(dc_annul && ex_annul, "R7 jump annuls both", {14'd0, dc_annul, ex_annul}, 16'h0003);
    step(1, 1, 16'h4555, 0, 0);
    chk(pre_wr == 1'b0, "R9 annulled no write", {15'd0, pre_wr}, 16'h0000);
    step(1, 1, 16'h4666, 0, 0);

    step(1, 1, 16'hB000, 1, 0);
    step(1, 1, 16'h4777, 0, 0);
    chk(dc_insn == 16'h4777, "R6 deferred behind branch", dc_insn, 16'h4777);
    step(1, 1, 16'h4888, 0, 1);
    chk(dc_insn == 16'h4888, "R6 deferred by redirect", dc_insn, 16'h4888);
    step(1, 1, 16'h4999, 0, 0);
    chk(dc_insn == 16'hAE08, "R4 late insertion", dc_insn, 16'hAE08);

    step(1, 1, 16'hC000, 0, 0);
    step(1, 1, 16'h0555, 0, 0);
    step(1, 1, 16'h0666, 0, 0);
    step(1, 1, 16'hC000, 0, 0);
    step(1, 1, 16'h07F7, 0, 0);
    step(1, 1, 16'h0888, 0, 0);
    chk(pre_wr == 1'b1, "R10 call writes r15", {15'd0, pre_wr}, 16'h0001);
    chk(pre_byp == 1'b1, "R10 bypass from r15", {15'd0, pre_byp}, 16'h0001);

    for (int k = 0; k < 4000; k++) begin
      logic [31:0] r;
      r = $urandom();
      step(r[0] | r[1], r[2], r[31:16], r[7:3] == 5'd0, r[8]);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule